// File: doc/BRIEF.md
# Sound Channel Note-Duration Timer

This block times how long one square-wave sound channel keeps sounding. A small frame sequencer takes a tick at the frame rate and walks a fixed five-step pattern, issuing quarter-frame and half-frame strobes. The half-frame strobes run down an 8-bit duration counter. The counter's nonzero state drives a flag that gates the channel's audio.

Software reaches the block through a byte-wide register write port with four slots, and through a separate status write that carries the channel's enable bit. A write to the duration slot picks one of 32 fixed load values with a 5-bit code. The load takes place only while the channel is enabled. The same write sends a start pulse to the envelope unit. A control-slot bit freezes the counter. A status write with the enable bit clear silences the channel at once.

Top module: `tone_duration_ctrl`

## Requirements
- R1: After reset, the duration count is 0, the active flag is low, both strobes are low, the sequencer is at step 0 and the channel is disabled.
- R2: Each `frame_tick` advances the sequencer by one step, through steps 0,1,2,3,4 and then back to 0. The strobes for the step current at the tick appear in the cycle after that tick.
- R3: Steps 0 and 2 raise only `quarter_stb`. Steps 1 and 4 raise both `half_stb` and `quarter_stb`. Step 3 raises neither. `half_stb` never appears without `quarter_stb`.
- R4: A write to slot 3 (`reg_sel`=3) takes bits 7:3 as a code from 0 to 31 and loads the count from the fixed table. Codes 0..15 give 10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14. Codes 16..31 give 12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30. The new count is visible after the write's clock edge.
- R5: A slot-3 write has no effect on the count while the channel is disabled.
- R6: On each half-frame strobe the count drops by one, one cycle after the strobe. It does not drop if the counter is already 0.
- R7: While the halt bit (bit 5 of the slot-0 control byte) is 1, half-frame strobes leave the count unchanged.
- R8: A status write with bit `CHAN_BIT` (default bit 0) at 0 disables the channel and forces the count to 0 at the next edge. This wins over a load in the same cycle. A status write with the bit at 1 enables the channel and leaves the count unchanged.
- R9: A load in the same cycle as a half-frame strobe takes the table value, with no decrement.
- R10: A loading slot-3 write raises `env_start` for exactly one cycle, together with the new count. Writes that do not load leave it low.
- R11: `len_active` is high exactly when the count is nonzero. Writes to slots 1 and 2 change neither the count nor the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_tick | input | 1 | One-cycle frame-rate tick |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register slot: 0 control, 1 sweep, 2 period low, 3 duration/period high |
| reg_wdata | input | 8 | Register write data |
| stat_wr | input | 1 | Status write strobe |
| stat_wdata | input | 8 | Status byte; bit CHAN_BIT is this channel's enable |
| quarter_stb | output | 1 | Quarter-frame strobe |
| half_stb | output | 1 | Half-frame strobe |
| env_start | output | 1 | Envelope restart pulse |
| len_count | output | 8 | Current duration count |
| len_active | output | 1 | Count is nonzero; gates audio |

## Verification
The assertions assume `frame_tick` is a single-cycle pulse with at least one idle cycle after it. The strobe properties depend on this, because a tick held high would make each later strobe follow a tick as well. The bench only pulses the tick for one cycle and always follows it with idle cycles. The decrement and hold properties also assume that no other write lands in the same cycle. The bench drives same-cycle collisions only in the tasks aimed at R8 and R9, and the properties exclude those cycles through their antecedents.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

  localparam int unsigned CNT_W = 8;
  localparam int unsigned CODE_W = 5;

  typedef logic [CNT_W-1:0] cnt_t;

  typedef struct packed {
    logic half;
    logic quarter;
  } strobe_t;

  // Duration load value for a 5-bit code.
  function automatic cnt_t dur_lookup(input logic [CODE_W-1:0] code);
    cnt_t v;
    case (code)
      5'd0:  v = 8'd10;   5'd1:  v = 8'd254;
      5'd2:  v = 8'd20;   5'd3:  v = 8'd2;
      5'd4:  v = 8'd40;   5'd5:  v = 8'd4;
      5'd6:  v = 8'd80;   5'd7:  v = 8'd6;
      5'd8:  v = 8'd160;  5'd9:  v = 8'd8;
      5'd10: v = 8'd60;   5'd11: v = 8'd10;
      5'd12: v = 8'd14;   5'd13: v = 8'd12;
      5'd14: v = 8'd26;   5'd15: v = 8'd14;
      5'd16: v = 8'd12;   5'd17: v = 8'd16;
      5'd18: v = 8'd24;   5'd19: v = 8'd18;
      5'd20: v = 8'd48;   5'd21: v = 8'd20;
      5'd22: v = 8'd96;   5'd23: v = 8'd22;
      5'd24: v = 8'd192;  5'd25: v = 8'd24;
      5'd26: v = 8'd72;   5'd27: v = 8'd26;
      5'd28: v = 8'd16;   5'd29: v = 8'd28;
      5'd30: v = 8'd32;   default: v = 8'd30;
    endcase
    return v;
  endfunction

  // Strobes issued by each sequencer step.
  function automatic strobe_t step_decode(input logic [2:0] step);
    strobe_t s;
    case (step)
      3'd0, 3'd2: s = '{half: 1'b0, quarter: 1'b1};
      3'd1, 3'd4: s = '{half: 1'b1, quarter: 1'b1};
      default:    s = '{half: 1'b0, quarter: 1'b0};
    endcase
    return s;
  endfunction

  // Next counter value; clear beats load, load beats decrement.
  function automatic cnt_t dur_next(input cnt_t cur, input logic clr,
                                    input logic load, input cnt_t ld_val,
                                    input logic dec, input logic halt);
    cnt_t n;
    if (clr)                             n = '0;
    else if (load)                       n = ld_val;
    else if (dec && !halt && cur != '0)  n = cur - 1'b1;
    else                                 n = cur;
    return n;
  endfunction

endpackage

// File: rtl/tdc_frame_seq.sv
module tdc_frame_seq
  import tdc_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  output logic quarter_stb,
  output logic half_stb
);
  localparam int unsigned STEP_W = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1;
  localparam logic [STEP_W-1:0] LAST = STEP_W'(NUM_STEPS - 1);

  logic [STEP_W-1:0] step_q;
  strobe_t           dec_s;

  always_comb dec_s = step_decode(3'(step_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= '0;
      quarter_stb <= 1'b0;
      half_stb    <= 1'b0;
    end else begin
      quarter_stb <= tick & dec_s.quarter;
      half_stb    <= tick & dec_s.half;
      if (tick) step_q <= (step_q == LAST) ? '0 : step_q + 1'b1;
    end
  end
endmodule

// File: rtl/tdc_len_counter.sv
module tdc_len_counter
  import tdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_evt,
  input  logic load_evt,
  input  cnt_t load_val,
  input  logic dec_evt,
  input  logic halt,
  output cnt_t count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= dur_next(count, clr_evt, load_evt, load_val, dec_evt, halt);
  end
endmodule

// File: rtl/tone_duration_ctrl.sv
module tone_duration_ctrl
  import tdc_pkg::*;
#(
  parameter int unsigned NUM_STEPS = 5,
  parameter int unsigned CHAN_BIT  = 0,
  parameter int unsigned HALT_BIT  = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_tick,
  input  logic       reg_wr,
  input  logic [1:0] reg_sel,
  input  logic [7:0] reg_wdata,
  input  logic       stat_wr,
  input  logic [7:0] stat_wdata,
  output logic       quarter_stb,
  output logic       half_stb,
  output logic       env_start,
  output logic [7:0] len_count,
  output logic       len_active
);
  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DUR  = 2'd3;

  logic chan_en_q;
  logic halt_q;
  logic load_evt;
  logic clr_evt;
  cnt_t load_val;

  // Named events used by the checker.
  assign clr_evt  = stat_wr & ~stat_wdata[CHAN_BIT];
  assign load_evt = reg_wr & (reg_sel == SEL_DUR) & chan_en_q & ~clr_evt;
  assign load_val = dur_lookup(reg_wdata[7:8-CODE_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en_q <= 1'b0;
      halt_q    <= 1'b0;
      env_start <= 1'b0;
    end else begin
      if (stat_wr) chan_en_q <= stat_wdata[CHAN_BIT];
      if (reg_wr && reg_sel == SEL_CTRL) halt_q <= reg_wdata[HALT_BIT];
      env_start <= load_evt;
    end
  end

  tdc_frame_seq #(.NUM_STEPS(NUM_STEPS)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(frame_tick),
    .quarter_stb(quarter_stb), .half_stb(half_stb)
  );

  tdc_len_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .clr_evt(clr_evt), .load_evt(load_evt),
    .load_val(load_val), .dec_evt(half_stb), .halt(halt_q), .count(len_count)
  );

  assign len_active = (len_count != '0);
endmodule

// File: rtl/tone_duration_chk.sv
module tone_duration_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_tick,
  input logic       quarter_stb,
  input logic       half_stb,
  input logic       env_start,
  input logic [7:0] len_count,
  input logic       len_active,
  input logic       load_evt,
  input logic       clr_evt,
  input logic       halt_q
);
  // R2
  strobe_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quarter_stb |-> $past(frame_tick));

  // R3
  half_implies_quarter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_stb |-> quarter_stb);

  // R6
  dec_by_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_stb && !halt_q && !load_evt && !clr_evt && len_count != 8'd0)
      |=> len_count == $past(len_count) - 8'd1);

  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_stb && halt_q && !load_evt && !clr_evt) |=> $stable(len_count));

  // R8
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> len_count == 8'd0);

  // R10
  start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> env_start);

  // R4
  rise_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (len_count > $past(len_count)) |-> $past(load_evt));

  // R11
  active_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_active == ($countones(len_count) != 0));
endmodule

bind tone_duration_ctrl tone_duration_chk u_chk (
  .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick),
  .quarter_stb(quarter_stb), .half_stb(half_stb), .env_start(env_start),
  .len_count(len_count), .len_active(len_active), .load_evt(load_evt),
  .clr_evt(clr_evt), .halt_q(halt_q)
);

// File: tb/sim_tone_duration_ctrl.sv
module sim_tone_duration_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame_tick = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic       stat_wr = 1'b0;
  logic [7:0] stat_wdata = 8'd0;
  logic       quarter_stb, half_stb, env_start, len_active;
  logic [7:0] len_count;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // Bench model state
  int m_step = 0;
  int m_cnt = 0;
  bit m_halt = 0;
  bit m_en = 0;

  int tbl [32] = '{10,254,20,2,40,4,80,6,160,8,60,10,14,12,26,14,
                   12,16,24,18,48,20,96,22,192,24,72,26,16,28,32,30};

  always #10 clk = ~clk;

  tone_duration_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .reg_wr(reg_wr),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .quarter_stb(quarter_stb), .half_stb(half_stb),
    .env_start(env_start), .len_count(len_count), .len_active(len_active)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit step_half(input int s);
    return (s == 1) || (s == 4);
  endfunction
  function automatic bit step_qtr(input int s);
    return s != 3;
  endfunction

  task automatic check_count(input string req);
    check(req, len_count, m_cnt);
    check({req, " active"}, len_active, (m_cnt != 0));
  endtask

  // One tick; check strobes, then let the counter settle.
  task automatic do_tick(input string req);
    bit h;
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) frame_tick = 1'b0;
    h = step_half(m_step);
    check({req, " quarter"}, quarter_stb, step_qtr(m_step));
    check({req, " half"}, half_stb, h);
    m_step = (m_step + 1) % 5;
    @(negedge clk);
    if (h && !m_halt && m_cnt != 0) m_cnt--;
    check_count(req);
  endtask

  task automatic wr_reg(input logic [1:0] sel, input logic [7:0] d, input string req);
    @(negedge clk) begin reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; end
    @(negedge clk) reg_wr = 1'b0;
    if (sel == 2'd0) m_halt = d[5];
    if (sel == 2'd3 && m_en) m_cnt = tbl[d[7:3]];
    check({req, " env_start"}, env_start, (sel == 2'd3 && m_en));
    check_count(req);
  endtask

  task automatic wr_stat(input logic [7:0] d, input string req);
    @(negedge clk) begin stat_wr = 1'b1; stat_wdata = d; end
    @(negedge clk) stat_wr = 1'b0;
    m_en = d[0];
    if (!d[0]) m_cnt = 0;
    check_count(req);
  endtask

  task automatic t_reset;
    check("R1 count", len_count, 0);
    check("R1 active", len_active, 0);
    check("R1 quarter", quarter_stb, 0);
    check("R1 half", half_stb, 0);
    check("R1 env", env_start, 0);
  endtask

  task automatic t_disabled_load;
    wr_reg(2'd3, 8'h08, "R5 load while disabled");
  endtask

  task automatic t_table;
    wr_stat(8'h01, "R8 enable no effect");
    for (int i = 0; i < 32; i++) wr_reg(2'd3, 8'(i << 3) | 8'h05, "R4 table");
  endtask

  task automatic t_sequence;
    wr_reg(2'd3, 8'h08, "R10 load 254");
    for (int i = 0; i < 12; i++) do_tick("R2 R3 R6 sequence");
  endtask

  task automatic t_ignored_slots;
    wr_reg(2'd1, 8'hFF, "R11 sweep slot ignored");
    wr_reg(2'd2, 8'hFF, "R11 period slot ignored");
  endtask

  task automatic t_halt;
    wr_reg(2'd0, 8'h20, "R7 halt on");
    for (int i = 0; i < 5; i++) do_tick("R7 halted");
    wr_reg(2'd0, 8'h00, "R7 halt off");
  endtask

  task automatic t_floor;
    wr_reg(2'd3, 8'h18, "R6 load 2");
    for (int i = 0; i < 8; i++) do_tick("R6 floor at zero");
    check("R6 final zero", len_count, 0);
  endtask

  task automatic t_load_vs_half;
    while (!step_half(m_step)) do_tick("R9 align");
    @(negedge clk) frame_tick = 1'b1;
    @(negedge clk) begin
      frame_tick = 1'b0; reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 8'h00;
    end
    check("R9 half present", half_stb, 1);
    m_step = (m_step + 1) % 5;
    @(negedge clk) reg_wr = 1'b0;
    m_cnt = 10;
    check("R9 load wins", len_count, 10);
    check("R10 env pulse", env_start, 1);
    @(negedge clk);
    check("R10 env one cycle", env_start, 0);
  endtask

  task automatic t_disable;
    @(negedge clk) begin
      stat_wr = 1'b1; stat_wdata = 8'h00; reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 8'h08;
    end
    @(negedge clk) begin stat_wr = 1'b0; reg_wr = 1'b0; end
    m_en = 0; m_cnt = 0;
    check("R8 clear beats load", len_count, 0);
    check("R10 no start on clear", env_start, 0);
    wr_stat(8'h01, "R8 re-enable keeps zero");
    wr_reg(2'd3, 8'h48, "R4 reload after enable");
    wr_stat(8'hFE, "R8 disable clears");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_disabled_load();
    t_table();
    t_sequence();
    t_ignored_slots();
    t_halt();
    t_floor();
    t_load_vs_half();
    t_disable();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule